// File: doc/BRIEF.md
# Two-Bank Set/Clear GPIO Controller

This block controls 32 general purpose pins, arranged as two banks of 16 behind a 16-bit register bus. Each bank owns four registers: a direction register, a read-only level register, a write-ones-to-set port and a write-ones-to-clear port. Software changes individual output pins without a read-modify-write sequence. The set and clear ports of a bank sit at addresses that differ only by an XOR with 0xC, so the opposite action is reached by flipping two address bits. The second bank repeats the first bank's layout two bytes higher.

The block drives an output-enable and an output value for every pin. It samples the pin inputs through a synchronizer. The bus is a plain single-cycle strobe interface: a write takes effect at the clock edge where it is presented. A read loads the read data register at the edge where the read strobe is high. Pin multiplexing and the bridge to a system bus sit outside this block.

Top module: `gpio_setclr_ctrl`

## Requirements
- R1: After reset every pin is an input (`pin_oe` all zero), every output latch is zero (`pin_out` all zero) and `bus_rdata` is zero.
- R2: A write to the direction register (byte address 0xC2A for bank 0, 0xC2C for bank 1) replaces all 16 direction bits of that bank. Bit i set to 1 makes pin 16*bank+i an output on `pin_oe` from the cycle after the write. A read of the same address returns the stored value.
- R3: A write to the set port (0xC34 for bank 0, 0xC36 for bank 1) forces to 1 every output latch bit whose data bit is 1 and leaves the others unchanged. The result appears on `pin_out` from the cycle after the write.
- R4: A write to the clear port (0xC38 for bank 0, 0xC3A for bank 1) forces to 0 every output latch bit whose data bit is 1 and leaves the others unchanged.
- R5: For each bank, the clear port address equals the set port address XOR 0xC. A write at (set address XOR 0xC) therefore clears exactly the bits written.
- R6: A read of the level register (0xC30 for bank 0, 0xC32 for bank 1) returns, for each bit, the output latch if the pin is an output, and otherwise the pin input delayed through a two-stage synchronizer. A pin change driven just after a clock edge is visible to a read whose strobe is sampled at the third following edge, and not at the second.
- R7: `bus_rdata` changes only at an edge where `bus_rd` is high, and keeps its value otherwise, even while register contents change.
- R8: Writes to any address other than the direction, set and clear addresses have no effect on any pin. This includes the level registers and all odd addresses. Reads of any address other than the direction and level registers (set and clear ports included) return zero.
- R9: The output latch is kept while a pin is an input. When the pin is turned into an output, its level read and `pin_out` show the previously set latch value.
- R10: A write to one bank leaves the direction and latch bits of the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, loaded at the edge of a read |
| pin_in | input | 32 | Asynchronous pin input levels |
| pin_oe | output | 32 | Output enable per pin (1 = output) |
| pin_out | output | 32 | Output value per pin |

## Verification
Two functions can land in the same cycle: the synchronizer presenting a new input level, and a bus read capturing the level register. The bench changes an input pin just after an edge. It then issues one level read whose strobe is sampled at the second following edge, and a second read at the third edge. The first read must return the old level and the second the new one, which pins the synchronizer depth and the non-blocking capture. The bench also sweeps every bit of every register of both banks and the whole neighbouring address window. Every result is judged against a model that the bench computes from the address arithmetic alone.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;

  localparam int unsigned BUS_W = 16;

  typedef enum logic [2:0] {
    KIND_NONE = 3'd0,
    KIND_DIR  = 3'd1,
    KIND_LVL  = 3'd2,
    KIND_SET  = 3'd3,
    KIND_CLR  = 3'd4
  } reg_kind_e;

  // address of a bank's copy of a register
  function automatic int unsigned bank_addr(input int unsigned base,
                                            input int unsigned bank,
                                            input int unsigned stride);
    return base + bank * stride;
  endfunction

  // next value of an output latch under set/clear strobes
  function automatic logic [BUS_W-1:0] latch_next(input logic [BUS_W-1:0] cur,
                                                   input logic [BUS_W-1:0] wdata,
                                                   input logic             do_set,
                                                   input logic             do_clr);
    logic [BUS_W-1:0] nx;
    nx = cur;
    if (do_set) nx = nx | wdata;
    if (do_clr) nx = nx & ~wdata;
    return nx;
  endfunction

  // value seen in the level register
  function automatic logic [BUS_W-1:0] level_view(input logic [BUS_W-1:0] dir,
                                                   input logic [BUS_W-1:0] latch,
                                                   input logic [BUS_W-1:0] sync_in);
    return (dir & latch) | (~dir & sync_in);
  endfunction

endpackage

// File: rtl/gpio_setclr_sync.sv
module gpio_setclr_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) stg[s] <= '0;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_setclr_dec.sv
module gpio_setclr_dec
  import gpio_setclr_pkg::*;
#(
  parameter int unsigned NBANK    = 2,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DIR_BASE = 32'hC2A,
  parameter int unsigned LVL_BASE = 32'hC30,
  parameter int unsigned SET_BASE = 32'hC34,
  parameter int unsigned CLR_BASE = 32'hC38,
  parameter int unsigned STRIDE   = 2,
  localparam int unsigned BIDX_W  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [BIDX_W-1:0] bank
);

  always_comb begin
    kind = KIND_NONE;
    bank = '0;
    for (int b = 0; b < int'(NBANK); b++) begin
      if (addr == ADDR_W'(bank_addr(DIR_BASE, b, STRIDE))) begin
        kind = KIND_DIR;
        bank = BIDX_W'(b);
      end
      if (addr == ADDR_W'(bank_addr(LVL_BASE, b, STRIDE))) begin
        kind = KIND_LVL;
        bank = BIDX_W'(b);
      end
      if (addr == ADDR_W'(bank_addr(SET_BASE, b, STRIDE))) begin
        kind = KIND_SET;
        bank = BIDX_W'(b);
      end
      if (addr == ADDR_W'(bank_addr(CLR_BASE, b, STRIDE))) begin
        kind = KIND_CLR;
        bank = BIDX_W'(b);
      end
    end
  end

endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_setclr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_we,
  input  logic             set_we,
  input  logic             clr_we,
  input  logic [BUS_W-1:0] wdata,
  input  logic [BUS_W-1:0] pins_sync,
  output logic [BUS_W-1:0] dir_q,
  output logic [BUS_W-1:0] latch_q,
  output logic [BUS_W-1:0] level
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (dir_we) begin
      dir_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (set_we || clr_we) begin
      latch_q <= latch_next(latch_q, wdata, set_we, clr_we);
    end
  end

  assign level = level_view(dir_q, latch_q, pins_sync);

endmodule

// File: rtl/gpio_setclr_ctrl.sv
module gpio_setclr_ctrl
  import gpio_setclr_pkg::*;
#(
  parameter int unsigned NBANK       = 2,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIR_BASE    = 32'hC2A,
  parameter int unsigned LVL_BASE    = 32'hC30,
  parameter int unsigned SET_BASE    = 32'hC34,
  parameter int unsigned CLR_BASE    = 32'hC38,
  parameter int unsigned STRIDE      = 2,
  localparam int unsigned NPIN       = NBANK * BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic [NPIN-1:0]   pin_in,
  output logic [NPIN-1:0]   pin_oe,
  output logic [NPIN-1:0]   pin_out
);

  localparam int unsigned BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;

  // named internal events
  reg_kind_e          dec_kind;
  logic [BIDX_W-1:0]  dec_bank;
  logic [NBANK-1:0]   dir_we;
  logic [NBANK-1:0]   set_we;
  logic [NBANK-1:0]   clr_we;
  logic [NPIN-1:0]    pins_sync;
  logic [BUS_W-1:0]   dir_arr   [NBANK];
  logic [BUS_W-1:0]   latch_arr [NBANK];
  logic [BUS_W-1:0]   level_arr [NBANK];
  logic [BUS_W-1:0]   rd_next;

  gpio_setclr_sync #(
    .W      (NPIN),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_in),
    .q     (pins_sync)
  );

  gpio_setclr_dec #(
    .NBANK    (NBANK),
    .ADDR_W   (ADDR_W),
    .DIR_BASE (DIR_BASE),
    .LVL_BASE (LVL_BASE),
    .SET_BASE (SET_BASE),
    .CLR_BASE (CLR_BASE),
    .STRIDE   (STRIDE)
  ) u_dec (
    .addr (bus_addr),
    .kind (dec_kind),
    .bank (dec_bank)
  );

  for (genvar b = 0; b < int'(NBANK); b++) begin : g_bank
    assign dir_we[b] = bus_wr && (dec_kind == KIND_DIR) && (dec_bank == BIDX_W'(b));
    assign set_we[b] = bus_wr && (dec_kind == KIND_SET) && (dec_bank == BIDX_W'(b));
    assign clr_we[b] = bus_wr && (dec_kind == KIND_CLR) && (dec_bank == BIDX_W'(b));

    gpio_setclr_bank u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .dir_we    (dir_we[b]),
      .set_we    (set_we[b]),
      .clr_we    (clr_we[b]),
      .wdata     (bus_wdata),
      .pins_sync (pins_sync[b*BUS_W +: BUS_W]),
      .dir_q     (dir_arr[b]),
      .latch_q   (latch_arr[b]),
      .level     (level_arr[b])
    );

    assign pin_oe[b*BUS_W +: BUS_W]  = dir_arr[b];
    assign pin_out[b*BUS_W +: BUS_W] = latch_arr[b];
  end

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < int'(NBANK); b++) begin
      if (dec_bank == BIDX_W'(b)) begin
        if (dec_kind == KIND_DIR) rd_next = dir_arr[b];
        if (dec_kind == KIND_LVL) rd_next = level_arr[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_next;
    end
  end

endmodule

// File: rtl/gpio_setclr_chk.sv
module gpio_setclr_chk
  import gpio_setclr_pkg::*;
#(
  parameter int unsigned NBANK    = 2,
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned DIR_BASE = 32'hC2A,
  parameter int unsigned LVL_BASE = 32'hC30,
  parameter int unsigned SET_BASE = 32'hC34,
  parameter int unsigned STRIDE   = 2,
  localparam int unsigned NPIN    = NBANK * BUS_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [NPIN-1:0]   pin_oe,
  input logic [NPIN-1:0]   pin_out
);

  logic rd_known;
  always_comb begin
    rd_known = 1'b0;
    for (int b = 0; b < int'(NBANK); b++) begin
      if (bus_addr == ADDR_W'(DIR_BASE + b * STRIDE)) rd_known = 1'b1;
      if (bus_addr == ADDR_W'(LVL_BASE + b * STRIDE)) rd_known = 1'b1;
    end
  end

  for (genvar b = 0; b < int'(NBANK); b++) begin : g_chk
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(DIR_BASE + b * STRIDE);
    localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(SET_BASE + b * STRIDE);
    localparam logic [ADDR_W-1:0] A_CLR = A_SET ^ ADDR_W'(12'hC);

    AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_DIR) |=> pin_oe[b*BUS_W +: BUS_W] == $past(bus_wdata)); // R2

    AST_SET_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_SET) |=>
        (pin_out[b*BUS_W +: BUS_W] & $past(bus_wdata)) == $past(bus_wdata)); // R3

    AST_SET_ZEROS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_SET) |=>
        ((pin_out[b*BUS_W +: BUS_W] ^ $past(pin_out[b*BUS_W +: BUS_W])) & ~$past(bus_wdata)) == '0); // R3

    AST_XOR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CLR) |=>
        (pin_out[b*BUS_W +: BUS_W] & $past(bus_wdata)) == '0); // R4
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R7

  AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !rd_known) |=> bus_rdata == '0); // R8

  AST_IDLE_PINS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> ($stable(pin_out) && $stable(pin_oe))); // R10

endmodule

bind gpio_setclr_ctrl gpio_setclr_chk #(
  .NBANK    (NBANK),
  .ADDR_W   (ADDR_W),
  .DIR_BASE (DIR_BASE),
  .LVL_BASE (LVL_BASE),
  .SET_BASE (SET_BASE),
  .STRIDE   (STRIDE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_oe    (pin_oe),
  .pin_out   (pin_out)
);

// File: tb/gpio_setclr_ctrl_bench.sv
module gpio_setclr_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_oe;
  logic [31:0] pin_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [15:0] m_dir [2];
  logic [15:0] m_lat [2];
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  gpio_setclr_ctrl u_gpio_setclr_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out)
  );

  function automatic logic [11:0] a_dir(input int b); return 12'hC2A + 12'(2*b); endfunction
  function automatic logic [11:0] a_lvl(input int b); return 12'hC30 + 12'(2*b); endfunction
  function automatic logic [11:0] a_set(input int b); return 12'hC34 + 12'(2*b); endfunction
  function automatic logic [11:0] a_clr(input int b); return 12'hC38 + 12'(2*b); endfunction

  function automatic logic [15:0] rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_oe();  return {m_dir[1], m_dir[0]}; endfunction
  function automatic logic [31:0] exp_out(); return {m_lat[1], m_lat[0]}; endfunction

  task automatic wr_dir(input int b, input logic [15:0] v);
    bus_write(a_dir(b), v); m_dir[b] = v;
  endtask
  task automatic wr_set(input int b, input logic [15:0] v);
    bus_write(a_set(b), v); m_lat[b] = m_lat[b] | v;
  endtask
  task automatic wr_clr(input int b, input logic [15:0] v);
    bus_write(a_clr(b), v); m_lat[b] = m_lat[b] & ~v;
  endtask

  function automatic bit is_defined_wr(input logic [11:0] a);
    return a == 12'hC2A || a == 12'hC2C || a == 12'hC34 || a == 12'hC36 ||
           a == 12'hC38 || a == 12'hC3A;
  endfunction
  function automatic bit is_defined_rd(input logic [11:0] a);
    return a == 12'hC2A || a == 12'hC2C || a == 12'hC30 || a == 12'hC32;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic [15:0] lv;
    m_dir[0] = '0; m_dir[1] = '0; m_lat[0] = '0; m_lat[1] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 rdata", {16'h0, bus_rdata}, 32'h0);
    bus_read(a_dir(1), rd);
    chk("R1 dir1", {16'h0, rd}, 32'h0);

    // R2 direction: walking one and patterns, R10 other bank untouched
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 16; i++) begin
        wr_dir(b, 16'(1) << i);
        chk("R2 walk pin_oe", pin_oe, exp_oe());
        bus_read(a_dir(b), rd);
        chk("R2 walk readback", {16'h0, rd}, {16'h0, m_dir[b]});
      end
      for (int k = 0; k < 6; k++) begin
        wr_dir(b, rnd());
        chk("R2 R10 pattern pin_oe", pin_oe, exp_oe());
      end
    end

    // R3 / R4 single bits
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 16; i++) begin
        wr_set(b, 16'(1) << i);
        chk("R3 set bit", pin_out, exp_out());
      end
      for (int i = 0; i < 16; i += 2) begin
        wr_clr(b, 16'(1) << i);
        chk("R4 clr bit", pin_out, exp_out());
      end
    end
    // R3 / R4 / R10 mixed patterns
    for (int k = 0; k < 24; k++) begin
      int b;
      b = k % 2;
      if (k % 3 == 0) begin
        wr_clr(b, rnd());
        chk("R4 R10 clr pattern", pin_out, exp_out());
      end else begin
        wr_set(b, rnd());
        chk("R3 R10 set pattern", pin_out, exp_out());
      end
    end

    // R5 toggle via XOR 0xC on the set address
    for (int b = 0; b < 2; b++) begin
      for (int i = 0; i < 16; i++) begin
        wr_set(b, 16'(1) << i);
        chk("R5 set before flip", pin_out, exp_out());
        bus_write(a_set(b) ^ 12'hC, 16'(1) << i);
        m_lat[b] = m_lat[b] & ~(16'(1) << i);
        chk("R5 flip clears", pin_out, exp_out());
      end
    end

    // R6 level read with mixed directions
    for (int k = 0; k < 10; k++) begin
      wr_dir(0, rnd()); wr_dir(1, rnd());
      wr_set(0, rnd()); wr_clr(1, rnd());
      @(negedge clk);
      pin_in = {rnd(), rnd()};
      repeat (3) @(negedge clk);
      for (int b = 0; b < 2; b++) begin
        lv = (m_dir[b] & m_lat[b]) | (~m_dir[b] & pin_in[b*16 +: 16]);
        bus_read(a_lvl(b), rd);
        chk("R6 level mixed", {16'h0, rd}, {16'h0, lv});
      end
    end

    // R9 latch kept while input
    wr_dir(0, 16'h0000);
    wr_clr(0, 16'hFFFF);
    @(negedge clk); pin_in[15:0] = 16'h0000;
    wr_set(0, 16'h3C3C);
    repeat (3) @(negedge clk);
    bus_read(a_lvl(0), rd);
    chk("R9 input shows pins", {16'h0, rd}, 32'h0);
    wr_dir(0, 16'hFFFF);
    bus_read(a_lvl(0), rd);
    chk("R9 output shows kept latch", {16'h0, rd}, 32'h3C3C);
    chk("R9 pin_out", {16'h0, pin_out[15:0]}, 32'h3C3C);

    // R7 read data held without strobe
    bus_read(a_dir(0), rd);
    wr_dir(0, 16'h1234);
    repeat (2) @(negedge clk);
    chk("R7 rdata holds", {16'h0, bus_rdata}, 32'hFFFF);

    // R8 undefined addresses, level and set/clear reads
    wr_dir(0, 16'hA5A5); wr_dir(1, 16'h5AA5);
    wr_set(0, 16'h0F0F); wr_clr(0, 16'h00F0);
    wr_set(1, 16'hC3C3); wr_clr(1, 16'h0303);
    for (int a = 12'hC00; a < 12'hC80; a++) begin
      if (!is_defined_wr(12'(a))) begin
        bus_write(12'(a), 16'hFFFF);
        chk("R8 ignored write oe", pin_oe, exp_oe());
        bus_write(12'(a), 16'h0000);
        chk("R8 ignored write out", pin_out, exp_out());
      end
      if (!is_defined_rd(12'(a))) begin
        bus_read(12'(a), rd);
        chk("R8 undefined read zero", {16'h0, rd}, 32'h0);
      end
    end
    bus_write(12'h42A, 16'h0000);
    chk("R8 alias write", pin_oe, exp_oe());
    bus_read(12'h02A, rd);
    chk("R8 alias read", {16'h0, rd}, 32'h0);

    // R6 same-cycle: synchronizer update vs level read capture
    wr_dir(1, 16'h0000);
    @(negedge clk); pin_in[31:16] = 16'h0000;
    repeat (4) @(negedge clk);
    pin_in[31:16] = 16'hBEEF;          // just after an edge
    @(negedge clk);                    // edge 1 passed
    bus_rd = 1'b1; bus_addr = a_lvl(1); // sampled at edge 2
    @(negedge clk);
    chk("R6 read at second edge sees old", {16'h0, bus_rdata}, 32'h0);
    @(negedge clk);                    // sampled at edge 3
    bus_rd = 1'b0;
    chk("R6 read at third edge sees new", {16'h0, bus_rdata}, 32'hBEEF);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule